// File: doc/BRIEF.md
# Clock Source Controller with Two-Speed Start-Up and Failsafe Monitor

This block decides which oscillator feeds the system clock: an external oscillator, a fast internal oscillator or a slow internal one. It does not touch any clock itself. The oscillators are seen as a one-cycle edge pulse from the external source (`ext_edge`), a one-cycle pulse per slow internal period (`slow_tick`) and two stability inputs. From these the block produces a one-hot source select, a frequency code for the internal divider, a sticky failure flag and a flag showing that the monitor is armed.

After reset or a wake pulse, a crystal-type mode with two-speed start-up or failsafe enabled runs from the internal clock. It stays there while a start-up timer counts external edges, and then moves to the external clock. Clock-input and RC modes need no start-up wait. The failure monitor opens a window at each slow tick. If a whole slow period passes with no external edge, the block raises a sticky fail flag and falls back to the internal clock. In crystal modes the monitor stays off until the start-up timer has expired.

Software sees one 8-bit control and status register. Bit 7 reads 0. Bits 6:4 hold the internal frequency code. Bit 3 shows that the external clock is running. Bits 2 and 1 are the fast and slow stability flags. Bit 0 requests the internal clock.

Top module: `clksrc_ctrl`

## Requirements
- R1: While reset is held, the register reads bit 7 = 0, frequency code = 3'b110, bits 2 and 1 = 0 and bit 0 = 0.
- R2: While reset is held, bit 3 reads 0 when failsafe is enabled, or when two-speed start-up is on with a crystal mode (osc_mode 0, 1 or 2). Otherwise it reads 1. Modes 3 (clock input) and 4 (RC) are non-crystal.
- R3: When the internal clock is in use, `clk_sel_slow` is selected for frequency code 3'b000 and `clk_sel_fast` for any other code. `ircf_out` mirrors bits 6:4.
- R4: In a crystal mode with hold-off enabled, the fast internal clock drives the system until OST_CYCLES external edges have been counted. From then on `clk_sel_ext` = 1 and bit 3 = 1.
- R5: In non-crystal modes the external source is selected right after reset. With failsafe enabled, the monitor arms one cycle after reset is released.
- R6: In crystal modes `mon_armed` stays 0 until the start-up timer has expired.
- R7: An armed monitor that sees a full slow period with no external edge sets `fail_flag`. The flag holds until reset or wake. The next cycle selects the internal clock and clears bit 3.
- R8: External edges in every slow period never raise `fail_flag`.
- R9: Writes to bits 7, 3, 2 and 1 have no effect.
- R10: A change written to bit 0 takes effect only once the target source is stable. For the internal target that is the fast flag, or the slow flag when the code is 000. For the external target it means the start-up wait is over.
- R11: A wake pulse clears `fail_flag`, disarms the monitor and restarts the start-up timer.
- R12: Bits 2 and 1 follow `fast_stable` and `slow_stable` with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wake | input | 1 | One-cycle pulse on exit from sleep |
| osc_mode | input | 3 | Oscillator mode: 0..2 crystal types, 3 clock input, 4 RC |
| two_speed_en | input | 1 | Two-speed start-up enable |
| failsafe_en | input | 1 | Failure monitor enable |
| ext_edge | input | 1 | Pulse per sampled external clock edge |
| slow_tick | input | 1 | Pulse per slow internal clock period |
| fast_stable | input | 1 | Fast internal oscillator is stable |
| slow_stable | input | 1 | Slow internal oscillator is stable |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| ircf_out | output | 3 | Internal frequency code |
| clk_sel_ext | output | 1 | Select external clock |
| clk_sel_fast | output | 1 | Select fast internal clock |
| clk_sel_slow | output | 1 | Select slow internal clock |
| fail_flag | output | 1 | Sticky external clock failure |
| mon_armed | output | 1 | Failure monitor armed |

## Verification
The assertions check a set of rules on every cycle:
- the start-up counter stays in range and reaches its terminal count;
- a failure is sticky and always pulls the select away from the external clock;
- the monitor is never armed in a crystal mode before the timer expires;
- the external select never rises without a ready source;
- bit 0 never changes while its target is unstable.

The bench scenarios cover the rest: the reset value of bit 3 for each configuration, the exact edge count at which the switch happens, the failure window length, the effect of a wake pulse and the register's ignored bits.

// File: rtl/clksrc_pkg.sv
package clksrc_pkg;

  typedef struct packed {
    logic       rsv;
    logic [2:0] freq;
    logic       ext_run;
    logic       fast_ok;
    logic       slow_ok;
    logic       int_req;
  } ctrl_reg_t;

  function automatic logic is_crystal(input logic [2:0] mode);
    return mode <= 3'd2;
  endfunction

  function automatic logic needs_hold(input logic [2:0] mode, input logic two, input logic fs);
    return is_crystal(mode) && (two || fs);
  endfunction

  function automatic logic ext_run_reset(input logic [2:0] mode, input logic two, input logic fs);
    return !((is_crystal(mode) && two) || fs);
  endfunction

  function automatic logic code_is_slow(input logic [2:0] code);
    return code == 3'b000;
  endfunction

endpackage

// File: rtl/clksrc_ost.sv
module clksrc_ost #(
  parameter int OST_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic ext_edge,
  output logic done
);
  localparam int CW = $clog2(OST_CYCLES + 1);

  logic [CW-1:0] cnt;
  logic          last_edge;

  assign last_edge = ext_edge && !done && (cnt == CW'(OST_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (ext_edge && !done) begin
      if (last_edge) done <= 1'b1;
      else           cnt  <= cnt + 1'b1;
    end
  end

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(OST_CYCLES));
  p_done_on_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (last_edge && !restart) |=> done);
endmodule

// File: rtl/clksrc_fsmon.sv
module clksrc_fsmon (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic armed,
  input  logic ext_edge,
  input  logic slow_tick,
  output logic fail
);
  logic seen, win;
  logic fail_event;

  assign fail_event = armed && slow_tick && win && !seen && !ext_edge;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      seen <= 1'b0;
      win  <= 1'b0;
      fail <= 1'b0;
    end else if (!armed) begin
      seen <= 1'b0;
      win  <= 1'b0;
    end else if (slow_tick) begin
      if (fail_event) fail <= 1'b1;
      win  <= 1'b1;
      seen <= 1'b0;
    end else if (ext_edge) begin
      seen <= 1'b1;
    end
  end

  p_fail_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !restart) |=> fail);
  p_no_fail_unarmed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !fail) |=> !fail);
  p_edge_blocks_fail_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !fail && !restart) |=> !fail);
endmodule

// File: rtl/clksrc_regs.sv
module clksrc_regs
  import clksrc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wdata,
  input  logic       ext_run,
  input  logic       fast_raw,
  input  logic       slow_raw,
  input  logic       ext_ready,
  output logic [7:0] rdata,
  output logic [2:0] freq,
  output logic       int_sel
);
  logic [2:0] freq_q;
  logic       req_q, sel_q, fast_q, slow_q;
  logic       target_ok;
  ctrl_reg_t  view;

  assign target_ok = req_q ? (code_is_slow(freq_q) ? slow_q : fast_q) : ext_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      freq_q <= 3'b110;
      req_q  <= 1'b0;
      sel_q  <= 1'b0;
      fast_q <= 1'b0;
      slow_q <= 1'b0;
    end else begin
      fast_q <= fast_raw;
      slow_q <= slow_raw;
      if (we) begin
        freq_q <= wdata[6:4];
        req_q  <= wdata[0];
      end
      if ((sel_q != req_q) && target_ok) sel_q <= req_q;
    end
  end

  always_comb begin
    view.rsv     = 1'b0;
    view.freq    = freq_q;
    view.ext_run = ext_run;
    view.fast_ok = fast_q;
    view.slow_ok = slow_q;
    view.int_req = sel_q;
  end

  assign rdata   = view;
  assign freq    = freq_q;
  assign int_sel = sel_q;

  p_sel_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q != $past(sel_q)) |-> $past(target_ok));
endmodule

// File: rtl/clksrc_ctrl.sv
module clksrc_ctrl
  import clksrc_pkg::*;
#(
  parameter int OST_CYCLES = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wake,
  input  logic [2:0] osc_mode,
  input  logic       two_speed_en,
  input  logic       failsafe_en,
  input  logic       ext_edge,
  input  logic       slow_tick,
  input  logic       fast_stable,
  input  logic       slow_stable,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic [2:0] ircf_out,
  output logic       clk_sel_ext,
  output logic       clk_sel_fast,
  output logic       clk_sel_slow,
  output logic       fail_flag,
  output logic       mon_armed
);
  logic crystal, hold, ost_done, ext_ready, arm_next;
  logic int_sel, fail, armed_q, ext_q;
  logic [2:0] freq;

  assign crystal   = is_crystal(osc_mode);
  assign hold      = needs_hold(osc_mode, two_speed_en, failsafe_en);
  assign ext_ready = !hold || ost_done;
  assign arm_next  = failsafe_en && (!crystal || ost_done) && !wake;

  clksrc_ost #(.OST_CYCLES(OST_CYCLES)) u_ost (
    .clk(clk), .rst_n(rst_n), .restart(wake), .ext_edge(ext_edge), .done(ost_done)
  );

  clksrc_fsmon u_mon (
    .clk(clk), .rst_n(rst_n), .restart(wake), .armed(armed_q),
    .ext_edge(ext_edge), .slow_tick(slow_tick), .fail(fail)
  );

  clksrc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .wdata(reg_wdata), .ext_run(ext_q),
    .fast_raw(fast_stable), .slow_raw(slow_stable), .ext_ready(ext_ready),
    .rdata(reg_rdata), .freq(freq), .int_sel(int_sel)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      ext_q   <= ext_run_reset(osc_mode, two_speed_en, failsafe_en);
    end else begin
      armed_q <= arm_next;
      ext_q   <= ext_ready && !int_sel && !fail;
    end
  end

  assign clk_sel_ext  = ext_q;
  assign clk_sel_fast = !ext_q && !code_is_slow(freq);
  assign clk_sel_slow = !ext_q && code_is_slow(freq);
  assign ircf_out     = freq;
  assign fail_flag    = fail;
  assign mon_armed    = armed_q;

  p_fail_forces_int_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> !clk_sel_ext);
  p_arm_needs_ost_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_armed && crystal) |-> ost_done);
  p_ext_needs_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clk_sel_ext |-> $past(ext_ready));
  p_wake_disarms_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> (!mon_armed && !fail_flag));
endmodule

// File: tb/sim_clksrc_ctrl.sv
module sim_clksrc_ctrl;
  logic clk = 0, rst_n = 0, wake = 0;
  logic [2:0] osc_mode = 3'd1;
  logic two_speed_en = 1, failsafe_en = 1;
  logic ext_edge = 0, slow_tick = 0, fast_stable = 1, slow_stable = 1;
  logic reg_we = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic [2:0] ircf_out;
  logic clk_sel_ext, clk_sel_fast, clk_sel_slow, fail_flag, mon_armed;

  localparam int OSTN = 16;

  always #4 clk = ~clk;

  clksrc_ctrl #(.OST_CYCLES(OSTN)) u0 (
    .clk(clk), .rst_n(rst_n), .wake(wake), .osc_mode(osc_mode),
    .two_speed_en(two_speed_en), .failsafe_en(failsafe_en), .ext_edge(ext_edge),
    .slow_tick(slow_tick), .fast_stable(fast_stable), .slow_stable(slow_stable),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ircf_out(ircf_out),
    .clk_sel_ext(clk_sel_ext), .clk_sel_fast(clk_sel_fast), .clk_sel_slow(clk_sel_slow),
    .fail_flag(fail_flag), .mon_armed(mon_armed)
  );

  typedef struct {
    string      req;
    int         kind;
    logic [7:0] exp;
  } item_t;

  item_t q[$];
  int total = 0, bad = 0;
  bit finished = 0;

  // kinds: 0 register, 1 {ext,fast,slow}, 2 fail, 3 armed, 4 freq code
  function automatic logic [7:0] observe(input int kind);
    case (kind)
      0: return reg_rdata;
      1: return {5'd0, clk_sel_ext, clk_sel_fast, clk_sel_slow};
      2: return {7'd0, fail_flag};
      3: return {7'd0, mon_armed};
      default: return {5'd0, ircf_out};
    endcase
  endfunction

  task automatic expect_val(input string req, input int kind, input logic [7:0] exp);
    item_t it;
    it.req = req; it.kind = kind; it.exp = exp;
    q.push_back(it);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = q.pop_front();
        act = observe(it.kind);
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic edges(input int n);
    repeat (n) begin
      ext_edge = 1; cyc(1); ext_edge = 0; cyc(1);
    end
  endtask

  task automatic tick();
    slow_tick = 1; cyc(1); slow_tick = 0; cyc(1);
  endtask

  task automatic wr(input logic [7:0] d);
    reg_we = 1; reg_wdata = d; cyc(1); reg_we = 0;
  endtask

  task automatic do_reset(input logic [2:0] m, input logic two, input logic fs,
                          input logic [7:0] exp_in_reset, input string req);
    rst_n = 0; osc_mode = m; two_speed_en = two; failsafe_en = fs;
    cyc(2);
    expect_val(req, 0, exp_in_reset);
    cyc(1);
    rst_n = 1;
    cyc(1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    cyc(1);
    // Crystal mode (XT), two-speed and failsafe on
    do_reset(3'd1, 1, 1, 8'h60, "R1 R2 crystal reset value");
    expect_val("R3 R4 fast internal during start-up", 1, 8'b010);
    expect_val("R6 monitor off before timer", 3, 8'd0);
    expect_val("R12 stability flags one cycle late", 0, 8'h66);
    wr(8'h68);
    cyc(1);
    expect_val("R9 write to bit3 ignored", 0, 8'h66);
    edges(OSTN - 1);
    expect_val("R4 still internal one edge short", 1, 8'b010);
    expect_val("R6 still disarmed one edge short", 3, 8'd0);
    edges(1);
    expect_val("R4 external after last edge", 1, 8'b100);
    expect_val("R4 bit3 set after switch", 0, 8'h6E);
    expect_val("R6 armed after timer", 3, 8'd1);
    for (int i = 0; i < 4; i++) begin
      tick(); edges(1);
    end
    tick();
    expect_val("R8 no failure with edges", 2, 8'd0);
    expect_val("R8 still external", 1, 8'b100);
    tick();
    expect_val("R7 failure after silent period", 2, 8'd1);
    expect_val("R7 back to internal", 1, 8'b010);
    expect_val("R7 bit3 cleared", 0, 8'h66);
    edges(3);
    expect_val("R7 failure is sticky", 2, 8'd1);
    expect_val("R7 stays internal", 1, 8'b010);
    // Wake
    wake = 1; cyc(1); wake = 0; cyc(1);
    expect_val("R11 wake clears failure", 2, 8'd0);
    expect_val("R11 wake disarms", 3, 8'd0);
    expect_val("R11 internal while restarting", 1, 8'b010);
    edges(OSTN - 1);
    expect_val("R11 timer restarted", 1, 8'b010);
    edges(1);
    expect_val("R11 external after new count", 1, 8'b100);
    // Register behaviour
    fast_stable = 0; slow_stable = 0;
    cyc(2);
    expect_val("R12 flags drop", 0, 8'h68);
    wr(8'hEE);
    cyc(1);
    expect_val("R9 bits 7 2 1 ignored", 0, 8'h68);
    wr(8'h71);
    cyc(3);
    expect_val("R10 request held while fast unstable", 0, 8'h78);
    expect_val("R10 still external", 1, 8'b100);
    fast_stable = 1;
    cyc(4);
    expect_val("R10 internal once stable", 0, 8'h75);
    expect_val("R3 fast for code 111", 1, 8'b010);
    expect_val("R3 code output", 4, 8'd7);
    wr(8'h01);
    cyc(2);
    expect_val("R3 slow for code 000", 1, 8'b001);
    expect_val("R3 code output zero", 4, 8'd0);
    wr(8'h60);
    cyc(3);
    expect_val("R10 back to external when ready", 1, 8'b100);
    expect_val("R10 register after return", 0, 8'h6C);
    // Non-crystal modes
    do_reset(3'd3, 0, 0, 8'h68, "R2 clock-input reset value no failsafe");
    expect_val("R5 external right after reset", 1, 8'b100);
    do_reset(3'd4, 0, 1, 8'h60, "R2 RC reset value with failsafe");
    expect_val("R5 armed right after reset", 3, 8'd1);
    expect_val("R5 RC external immediately", 1, 8'b100);
    tick();
    expect_val("R7 first tick only opens window", 2, 8'd0);
    tick();
    expect_val("R7 failure in RC mode", 2, 8'd1);
    expect_val("R7 RC falls back to internal", 1, 8'b010);
    cyc(3);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule